// File: doc/BRIEF.md
# Flash Controller Protected Control Registers

This block holds the two byte-wide control and status registers that sit in front of an embedded flash engine. Software reaches them through a single-cycle register port. There is a write strobe and a read strobe, and a one-bit select picks register A (select 0) or register B (select 1). Read data is combinational on the current select and needs no handshake. The port takes one access per cycle, so no back-pressure applies. The flash engine reports three things: a ready level, a one-cycle program-error pulse and a one-cycle erase-error pulse. A clear-status strobe from the command path empties the error flags.

Three control bits guard against runaway code: the rewrite enable, the lock-bit disable and the erase-write mode select. Each becomes 1 only through a two-step write. Software first writes 0 to the bit and then writes 1 on the very next register access. An interrupt acknowledge or a DMA cycle in between cancels the sequence. The lock disable and the mode select also need the rewrite enable to be 1 already. Clearing the rewrite enable takes the mode select down with it. The stop bit can always be stored, but it drives the stop output only while rewrite is enabled.

Top module: `flashctl_regpair`

## Requirements
- R1: After reset, register A reads 0x01 (bit 0, the ready flag, is 1). Register B reads 0x00. The rewrite_en, lock_dis, mode_sel and stop_active outputs are 0.
- R2: Writing register A with bit 1 = 0, then on the next register access writing it with bit 1 = 1, sets rewrite_en (register A bit 1). Idle cycles with no access may lie between the two writes. A write of 1 that is not preceded in this way leaves the bit unchanged.
- R3: Any of the following cancels the pending sequence, so the write of 1 has no effect: an irq_ack or dma_cycle cycle between the two writes or on the same cycle as the write of 1, or any other register access (a read or a write) in between.
- R4: Register A bit 2 (lock_dis) follows the same 0-then-1 sequence. The completing write sets it only if rewrite_en is already 1 and that write also carries bit 1 = 1. A write with bit 2 = 0 clears it.
- R5: Register B bit 1 (mode_sel) follows the same 0-then-1 sequence on register B. It sets only while rewrite_en is 1, and it reads back on register B bit 1.
- R6: Writing register A with bit 1 = 0 clears both rewrite_en and mode_sel at the same clock edge.
- R7: Register A bit 3 stores any written value and reads it back. stop_active is 1 only while that bit and rewrite_en are both 1.
- R8: Register A bit 6 (program error) and bit 7 (erase error) set on their engine pulses and hold until clr_status. A pulse in the same cycle as clr_status wins. Bus writes do not change these bits.
- R9: Register A bit 0 shows eng_ready as it was one clock earlier.
- R10: Register A bits 5:4 and every register B bit other than bit 1 read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 = A, 1 = B |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (counts as an access) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq_ack | input | 1 | Interrupt acknowledge cycle |
| dma_cycle | input | 1 | DMA transfer cycle |
| eng_ready | input | 1 | Flash engine ready (1) / busy (0) |
| prog_err_pulse | input | 1 | Program ended in error |
| erase_err_pulse | input | 1 | Erase ended in error |
| clr_status | input | 1 | Clear both error flags |
| rewrite_en | output | 1 | CPU rewrite enable |
| lock_dis | output | 1 | Lock-bit protection disable |
| mode_sel | output | 1 | Erase-write mode select |
| stop_active | output | 1 | Flash stop / low-power request |

## Verification
The hardest cases to reach from the ports are the cancel windows. One is an interrupt acknowledge that lands on the very cycle of the completing write. The other is a sequence that stays armed across idle cycles yet is cancelled by a single intervening read. The bench times irq_ack and dma_cycle on the same negative edge that raises the second write strobe. It also runs a variant that leaves several idle cycles between the writes, and one that puts a lone read between them. This separates "any access cancels" from "time cancels".

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
  parameter int REG_W = 8;
  // bit positions software decodes
  localparam int B_RDY = 0;
  localparam int B_RWE = 1;
  localparam int B_LCK = 2;
  localparam int B_STP = 3;
  localparam int B_PER = 6;
  localparam int B_EER = 7;
  localparam int B_MOD = 1;
  // protected-bit guard indices
  localparam int N_PROT = 3;
  localparam int G_RWE  = 0;
  localparam int G_LCK  = 1;
  localparam int G_MOD  = 2;
  localparam int N_ERR  = 2;
endpackage

// File: rtl/flashctl_seqguard.sv
module flashctl_seqguard (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_access,
  input  logic abort,
  input  logic arm_wr,
  input  logic set_wr,
  output logic set_ok
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (abort)      armed_q <= 1'b0;
    else if (bus_access) armed_q <= arm_wr;
  end

  assign set_ok = set_wr & armed_q & ~abort;
endmodule

// File: rtl/flashctl_errflags.sv
module flashctl_errflags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic         clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag[i] <= 1'b0;
      else if (set_pulse[i]) flag[i] <= 1'b1;
      else if (clr)          flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flashctl_readmux.sv
module flashctl_readmux #(
  parameter int W = flashctl_pkg::REG_W
) (
  input  logic         sel,
  input  logic         ready,
  input  logic         rewrite,
  input  logic         lock,
  input  logic         stop,
  input  logic         perr,
  input  logic         eerr,
  input  logic         mode,
  output logic [W-1:0] rd_data
);
  import flashctl_pkg::*;
  logic [W-1:0] reg_a, reg_b;

  always_comb begin
    reg_a        = '0;
    reg_a[B_RDY] = ready;
    reg_a[B_RWE] = rewrite;
    reg_a[B_LCK] = lock;
    reg_a[B_STP] = stop;
    reg_a[B_PER] = perr;
    reg_a[B_EER] = eerr;
    reg_b        = '0;
    reg_b[B_MOD] = mode;
  end

  assign rd_data = sel ? reg_b : reg_a;
endmodule

// File: rtl/flashctl_regpair.sv
module flashctl_regpair
  import flashctl_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          irq_ack,
  input  logic          dma_cycle,
  input  logic          eng_ready,
  input  logic          prog_err_pulse,
  input  logic          erase_err_pulse,
  input  logic          clr_status,
  output logic          rewrite_en,
  output logic          lock_dis,
  output logic          mode_sel,
  output logic          stop_active
);
  logic wr_a, wr_b, access, abort;
  logic [N_PROT-1:0] arm_wr, set_wr, set_ok;
  logic [N_PROT-1:0] guard_sel;
  logic [N_PROT-1:0] guard_bit;
  logic ready_q, rwe_q, lck_q, mod_q, stp_q;
  logic [N_ERR-1:0] err_q;
  logic unused_wdata;

  assign wr_a   = wr_en & ~reg_sel;
  assign wr_b   = wr_en &  reg_sel;
  assign access = wr_en | rd_en;
  assign abort  = irq_ack | dma_cycle;
  assign unused_wdata = ^{wr_data[DW-1:4], wr_data[0]};

  // which register and data bit each guard watches
  always_comb begin
    guard_sel        = '0;
    guard_sel[G_MOD] = 1'b1;
    guard_bit[G_RWE] = wr_data[B_RWE];
    guard_bit[G_LCK] = wr_data[B_LCK];
    guard_bit[G_MOD] = wr_data[B_MOD];
  end

  for (genvar g = 0; g < N_PROT; g++) begin : g_guard
    logic hit;
    assign hit       = guard_sel[g] ? wr_b : wr_a;
    assign arm_wr[g] = hit & ~guard_bit[g];
    assign set_wr[g] = hit &  guard_bit[g];
    flashctl_seqguard u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_access(access),
      .abort     (abort),
      .arm_wr    (arm_wr[g]),
      .set_wr    (set_wr[g]),
      .set_ok    (set_ok[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      rwe_q   <= 1'b0;
      lck_q   <= 1'b0;
      mod_q   <= 1'b0;
      stp_q   <= 1'b0;
    end else begin
      ready_q <= eng_ready;
      if (arm_wr[G_RWE])      rwe_q <= 1'b0;
      else if (set_ok[G_RWE]) rwe_q <= 1'b1;
      if (arm_wr[G_LCK])      lck_q <= 1'b0;
      else if (set_ok[G_LCK] && rwe_q && wr_data[B_RWE]) lck_q <= 1'b1;
      if (arm_wr[G_RWE] || arm_wr[G_MOD]) mod_q <= 1'b0;
      else if (set_ok[G_MOD] && rwe_q)    mod_q <= 1'b1;
      if (wr_a) stp_q <= wr_data[B_STP];
    end
  end

  flashctl_errflags #(.N(N_ERR)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse({erase_err_pulse, prog_err_pulse}),
    .clr      (clr_status),
    .flag     (err_q)
  );

  flashctl_readmux #(.W(DW)) u_rd (
    .sel    (reg_sel),
    .ready  (ready_q),
    .rewrite(rwe_q),
    .lock   (lck_q),
    .stop   (stp_q),
    .perr   (err_q[0]),
    .eerr   (err_q[1]),
    .mode   (mod_q),
    .rd_data(rd_data)
  );

  assign rewrite_en  = rwe_q;
  assign lock_dis    = lck_q;
  assign mode_sel    = mod_q;
  assign stop_active = stp_q & rwe_q;
endmodule

// File: rtl/flashctl_regpair_chk.sv
module flashctl_regpair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_ack,
  input logic       dma_cycle,
  input logic       eng_ready,
  input logic       prog_err_pulse,
  input logic       erase_err_pulse,
  input logic       clr_status,
  input logic       rewrite_en,
  input logic       lock_dis,
  input logic       mode_sel,
  input logic       stop_active
);
  assert_rise_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_en) |-> $past(wr_en && !reg_sel && wr_data[1]));

  assert_rise_not_aborted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_en) |-> !$past(irq_ack || dma_cycle || rd_en));

  assert_lock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_dis) |-> $past(rewrite_en));

  assert_mode_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_sel) |-> $past(rewrite_en && wr_en && reg_sel));

  assert_master_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && !wr_data[1]) |=> (!rewrite_en && !mode_sel));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err_pulse |=> (reg_sel || rd_data[6]));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !erase_err_pulse) |=> (reg_sel || !rd_data[7]));

  assert_ready_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (reg_sel || rd_data[0] == $past(eng_ready)));
endmodule

bind flashctl_regpair flashctl_regpair_chk u_chk (.*);

// File: tb/flashctl_regpair_test.sv
`timescale 1ns/1ps
module flashctl_regpair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq_ack = 1'b0, dma_cycle = 1'b0, eng_ready = 1'b1;
  logic prog_err_pulse = 1'b0, erase_err_pulse = 1'b0, clr_status = 1'b0;
  logic rewrite_en, lock_dis, mode_sel, stop_active;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flashctl_regpair uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    reg_sel = sel; #1; v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0; irq_ack = 0; dma_cycle = 0;
    eng_ready = 1; prog_err_pulse = 0; erase_err_pulse = 0; clr_status = 0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  // write; optional abort on the same cycle
  task automatic wr(input logic sel, input logic [7:0] d, input logic irq = 0, input logic dma = 0);
    @(negedge clk); reg_sel = sel; wr_data = d; wr_en = 1; irq_ack = irq; dma_cycle = dma;
    @(negedge clk); wr_en = 0; irq_ack = 0; dma_cycle = 0;
  endtask

  task automatic rd(input logic sel);
    @(negedge clk); reg_sel = sel; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable_rewrite();
    wr(0, 8'h00); wr(0, 8'h02);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    peek(0, v); check("R1 regA", v, 8'h01);
    peek(1, v); check("R1 regB", v, 8'h00);
    check("R1 outs", {4'h0, rewrite_en, lock_dis, mode_sel, stop_active}, 8'h00);
  endtask

  task automatic t_rewrite();
    do_reset();
    wr(0, 8'h02);
    check("R2 lone 1 ignored", {7'h0, rewrite_en}, 8'h00);
    wr(0, 8'h00); idle(4); wr(0, 8'h02);
    check("R2 0 then 1 after idle", {7'h0, rewrite_en}, 8'h01);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    do_reset();
    wr(0, 8'h00); wr(0, 8'h02, 1'b1, 1'b0);
    check("R3 irq on set cycle", {7'h0, rewrite_en}, 8'h00);
    wr(0, 8'h00);
    @(negedge clk); dma_cycle = 1; @(negedge clk); dma_cycle = 0;
    wr(0, 8'h02);
    check("R3 dma between", {7'h0, rewrite_en}, 8'h00);
    wr(0, 8'h00); rd(1); wr(0, 8'h02);
    peek(0, v);
    check("R3 read between", v & 8'h02, 8'h00);
  endtask

  task automatic t_lock();
    do_reset();
    wr(0, 8'h00); wr(0, 8'h04);
    check("R4 lock without rewrite", {7'h0, lock_dis}, 8'h00);
    enable_rewrite();
    wr(0, 8'h02); wr(0, 8'h06);
    check("R4 lock set", {6'h0, rewrite_en, lock_dis}, 8'h03);
    wr(0, 8'h02);
    check("R4 lock cleared by 0", {7'h0, lock_dis}, 8'h00);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    do_reset();
    wr(1, 8'h00); wr(1, 8'h02);
    check("R5 mode without rewrite", {7'h0, mode_sel}, 8'h00);
    enable_rewrite();
    wr(1, 8'h00); wr(1, 8'h02);
    peek(1, v);
    check("R5 mode readback", v, 8'h02);
    wr(0, 8'h00);
    check("R6 master clear", {6'h0, rewrite_en, mode_sel}, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    do_reset();
    wr(0, 8'h08);
    peek(0, v);
    check("R7 stop stored", v & 8'h08, 8'h08);
    check("R7 no action while disabled", {7'h0, stop_active}, 8'h00);
    wr(0, 8'h0A);
    check("R7 stop active", {7'h0, stop_active}, 8'h01);
  endtask

  task automatic t_err();
    logic [7:0] v;
    do_reset();
    @(negedge clk); prog_err_pulse = 1; @(negedge clk); prog_err_pulse = 0;
    idle(2); peek(0, v);
    check("R8 prog err held", v & 8'hC0, 8'h40);
    @(negedge clk); erase_err_pulse = 1; @(negedge clk); erase_err_pulse = 0;
    wr(0, 8'h00); peek(0, v);
    check("R8 write keeps errs", v & 8'hC0, 8'hC0);
    @(negedge clk); clr_status = 1; erase_err_pulse = 1;
    @(negedge clk); clr_status = 0; erase_err_pulse = 0; peek(0, v);
    check("R8 set beats clear", v & 8'hC0, 8'h80);
    @(negedge clk); clr_status = 1; @(negedge clk); clr_status = 0; peek(0, v);
    check("R8 cleared", v & 8'hC0, 8'h00);
  endtask

  task automatic t_ready();
    logic [7:0] v;
    do_reset();
    @(negedge clk); eng_ready = 0; peek(0, v);
    check("R9 not yet", v & 8'h01, 8'h01);
    @(negedge clk); peek(0, v);
    check("R9 busy", v & 8'h01, 8'h00);
    eng_ready = 1; @(negedge clk); peek(0, v);
    check("R9 ready", v & 8'h01, 8'h01);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    do_reset();
    wr(0, 8'h30); peek(0, v);
    check("R10 regA 5:4", v, 8'h01);
    wr(1, 8'hFD); peek(1, v);
    check("R10 regB reserved", v, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset(); t_rewrite(); t_abort(); t_lock(); t_mode();
    t_stop(); t_err(); t_ready(); t_reserved();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule